// File: doc/BRIEF.md
# Accumulator ALU with Carry-Flag Semantics

This block is the arithmetic, logic and shift unit of a small accumulator machine. Each cycle it takes an 8-bit opcode, the accumulator value, one operand byte (already fetched from memory or taken from the instruction stream) and the one-bit carry flag. It returns the next accumulator value, the next carry flag, and a write enable that says whether the flag is updated by this opcode.

Subtraction works in two directions: operand minus accumulator, and accumulator minus operand. In both, the carry flag acts as an inverted borrow. It is 1 when no borrow occurred. On the chained forms, a flag of 0 takes one extra unit off the result. The rotate forms treat the flag as a ninth bit of the accumulator. Opcodes outside the ALU set pass the accumulator and flag through unchanged.

The datapath is combinational. A parameter selects whether a register stage sits on the outputs. The data width is a parameter (default 8). The opcode encoding is fixed at 8 bits.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 0xF4 and 0xFC give {flag,acc} = acc + operand. Opcodes 0x74 and 0x7C also add the incoming flag. The flag is the carry out of the top bit.
- R2: Opcodes 0xF5 and 0xFD give acc = operand − acc, truncated to the data width. The flag is 1 exactly when operand ≥ acc (no borrow).
- R3: Opcodes 0xF7 and 0xFF give acc = acc − operand, truncated. The flag is 1 exactly when acc ≥ operand.
- R4: The chained subtract opcodes 0x75/0x7D (operand − acc) and 0x77/0x7F (acc − operand) also subtract (1 − flag_in). The flag is 1 exactly when the full difference is non-negative.
- R5: Opcodes 0xF1/0xF9 give bitwise OR, 0xF2/0xFA give bitwise AND, and 0xF3/0xFB give bitwise XOR of operand and acc. The flag output equals flag_in and the flag write enable is 0.
- R6: Opcode 0xF6 shifts acc right with 0 entering the top bit. Opcode 0x76 shifts right with flag_in entering the top bit. In both, the old bit 0 becomes the flag.
- R7: Opcode 0xFE shifts acc left with 0 entering bit 0. Opcode 0x7E shifts left with flag_in entering bit 0. In both, the old top bit becomes the flag.
- R8: The flag write enable is 1 for every arithmetic and shift opcode listed in R1–R7, except the logic opcodes.
- R9: Every other opcode value drives acc_out = acc_in, flag_out = flag_in and flag_we = 0.
- R10: With OUT_REG = 1, the outputs show the result of the inputs sampled at the previous rising edge. A synchronous active-high reset drives all outputs to 0. With OUT_REG = 0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_code | input | 8 | Instruction opcode |
| acc_in | input | DATA_W | Current accumulator value |
| opnd_in | input | DATA_W | Memory or immediate operand |
| flag_in | input | 1 | Current carry / inverted-borrow flag |
| acc_out | output | DATA_W | Next accumulator value |
| flag_out | output | 1 | Next flag value |
| flag_we | output | 1 | High when the opcode writes the flag |

## Verification
The bench builds the block with DATA_W = 4 and OUT_REG = 1. At that width, every one of the 256 opcodes can be applied with every accumulator value, every operand value and both flag values, for 131072 vectors in all. This covers every carry and borrow boundary in both subtract directions, every shift-out bit, and the pass-through of non-ALU opcodes. The registered stage makes the one-cycle latency and the reset values observable.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    // Kind of work an opcode asks for.
    typedef enum logic [3:0] {
        OPK_NONE     = 4'd0,
        OPK_ADD      = 4'd1,
        OPK_SUB_OPND = 4'd2,  // operand minus accumulator
        OPK_SUB_ACC  = 4'd3,  // accumulator minus operand
        OPK_OR       = 4'd4,
        OPK_AND      = 4'd5,
        OPK_XOR      = 4'd6,
        OPK_SHR      = 4'd7,
        OPK_SHL      = 4'd8
    } op_kind_e;

    // Decoded control: kind plus whether the flag feeds the operation.
    typedef struct packed {
        op_kind_e kind;
        logic     chain;
    } op_ctl_t;

    localparam logic [3:0] GRP_PLAIN   = 4'hF;
    localparam logic [3:0] GRP_CHAINED = 4'h7;

    function automatic op_ctl_t decode_op(input logic [7:0] op);
        op_ctl_t c;
        c.kind  = OPK_NONE;
        c.chain = 1'b0;
        if (op[7:4] == GRP_PLAIN) begin
            case (op[2:0])
                3'd1:    c.kind = OPK_OR;
                3'd2:    c.kind = OPK_AND;
                3'd3:    c.kind = OPK_XOR;
                3'd4:    c.kind = OPK_ADD;
                3'd5:    c.kind = OPK_SUB_OPND;
                3'd6:    c.kind = op[3] ? OPK_SHL : OPK_SHR;
                3'd7:    c.kind = OPK_SUB_ACC;
                default: c.kind = OPK_NONE;
            endcase
        end else if (op[7:4] == GRP_CHAINED) begin
            c.chain = 1'b1;
            case (op[2:0])
                3'd4:    c.kind = OPK_ADD;
                3'd5:    c.kind = OPK_SUB_OPND;
                3'd6:    c.kind = op[3] ? OPK_SHL : OPK_SHR;
                3'd7:    c.kind = OPK_SUB_ACC;
                default: c.kind = OPK_NONE;
            endcase
            if (c.kind == OPK_NONE) c.chain = 1'b0;
        end
        return c;
    endfunction

    function automatic logic is_logic(input op_kind_e k);
        return (k == OPK_OR) || (k == OPK_AND) || (k == OPK_XOR);
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import acc_alu_pkg::*;
(
    input  logic [7:0] op_code,
    output op_ctl_t    ctl
);
    always_comb begin
        ctl = decode_op(op_code);
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_ctl_t             ctl,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   opnd,
    input  logic                flag_in,
    output logic [DATA_W-1:0]   sum,
    output logic                cout
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] a_side;
    logic [DATA_W-1:0] b_side;
    logic              cin;
    logic [SUM_W-1:0]  total;

    // Subtraction is x + ~y + 1; the chained forms replace the 1 by the flag.
    always_comb begin
        a_side = acc;
        b_side = opnd;
        cin    = ctl.chain ? flag_in : 1'b0;
        case (ctl.kind)
            OPK_SUB_OPND: begin
                a_side = opnd;
                b_side = ~acc;
                cin    = ctl.chain ? flag_in : 1'b1;
            end
            OPK_SUB_ACC: begin
                a_side = acc;
                b_side = ~opnd;
                cin    = ctl.chain ? flag_in : 1'b1;
            end
            default: ;
        endcase
        total = {1'b0, a_side} + {1'b0, b_side} + {{DATA_W{1'b0}}, cin};
    end

    assign sum  = total[DATA_W-1:0];
    assign cout = total[SUM_W-1];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_ctl_t             ctl,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   opnd,
    input  logic                flag_in,
    output logic [DATA_W-1:0]   res,
    output logic                shift_out
);
    localparam int TOP = DATA_W - 1;

    logic fill;
    assign fill = ctl.chain & flag_in;

    always_comb begin
        res       = acc;
        shift_out = flag_in;
        case (ctl.kind)
            OPK_OR:  res = acc | opnd;
            OPK_AND: res = acc & opnd;
            OPK_XOR: res = acc ^ opnd;
            OPK_SHR: begin
                res       = {fill, acc[TOP:1]};
                shift_out = acc[0];
            end
            OPK_SHL: begin
                res       = {acc[TOP-1:0], fill};
                shift_out = acc[TOP];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              flag_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              flag_out,
    output logic              flag_we
);
    localparam int TOP = DATA_W - 1;

    op_ctl_t           ctl;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_cout;
    logic [DATA_W-1:0] bit_res;
    logic              bit_shift_out;
    logic [DATA_W-1:0] nxt_acc;
    logic              nxt_flag;
    logic              nxt_we;

    alu_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .ctl     (ctl),
        .acc     (acc_in),
        .opnd    (opnd_in),
        .flag_in (flag_in),
        .sum     (arith_sum),
        .cout    (arith_cout)
    );

    alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .ctl       (ctl),
        .acc       (acc_in),
        .opnd      (opnd_in),
        .flag_in   (flag_in),
        .res       (bit_res),
        .shift_out (bit_shift_out)
    );

    // Result select.
    always_comb begin
        nxt_acc  = acc_in;
        nxt_flag = flag_in;
        nxt_we   = 1'b0;
        case (ctl.kind)
            OPK_ADD, OPK_SUB_OPND, OPK_SUB_ACC: begin
                nxt_acc  = arith_sum;
                nxt_flag = arith_cout;
                nxt_we   = 1'b1;
            end
            OPK_SHR, OPK_SHL: begin
                nxt_acc  = bit_res;
                nxt_flag = bit_shift_out;
                nxt_we   = 1'b1;
            end
            OPK_OR, OPK_AND, OPK_XOR: begin
                nxt_acc = bit_res;
            end
            default: ;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_out  <= '0;
                    flag_out <= 1'b0;
                    flag_we  <= 1'b0;
                end else begin
                    acc_out  <= nxt_acc;
                    flag_out <= nxt_flag;
                    flag_we  <= nxt_we;
                end
            end

            AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
                !rst |=> (acc_out == $past(nxt_acc) && flag_out == $past(nxt_flag)
                          && flag_we == $past(nxt_we))); // R10
        end else begin : g_comb
            assign acc_out  = nxt_acc;
            assign flag_out = nxt_flag;
            assign flag_we  = nxt_we;
        end
    endgenerate

    AST_PASS_OTHER: assert property (@(posedge clk) disable iff (rst)
        (ctl.kind == OPK_NONE) |-> (nxt_acc == acc_in && nxt_flag == flag_in && !nxt_we)); // R9

    AST_LOGIC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        is_logic(ctl.kind) |-> (nxt_flag == flag_in && !nxt_we)); // R5

    AST_SHR_OUT_BIT: assert property (@(posedge clk) disable iff (rst)
        (ctl.kind == OPK_SHR) |-> (nxt_flag == acc_in[0] && nxt_acc[TOP-1:0] == acc_in[TOP:1])); // R6

    AST_SHL_OUT_BIT: assert property (@(posedge clk) disable iff (rst)
        (ctl.kind == OPK_SHL) |-> (nxt_flag == acc_in[TOP] && nxt_acc[TOP:1] == acc_in[TOP-1:0])); // R7

    AST_SUB_EQUAL_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        ((ctl.kind == OPK_SUB_ACC || ctl.kind == OPK_SUB_OPND) && !ctl.chain && acc_in == opnd_in)
        |-> (arith_cout && arith_sum == '0)); // R2

    AST_ADD_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (ctl.kind == OPK_ADD && !ctl.chain && opnd_in == '0) |-> (arith_sum == acc_in && !arith_cout)); // R1
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    localparam int W = 4;
    localparam int M = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   op_code = 8'h00;
    logic [W-1:0] acc_in = '0;
    logic [W-1:0] opnd_in = '0;
    logic         flag_in = 1'b0;
    logic [W-1:0] acc_out;
    logic         flag_out;
    logic         flag_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acc_alu #(.DATA_W(W), .OUT_REG(1'b1)) u_acc_alu (
        .clk      (clk),
        .rst      (rst),
        .op_code  (op_code),
        .acc_in   (acc_in),
        .opnd_in  (opnd_in),
        .flag_in  (flag_in),
        .acc_out  (acc_out),
        .flag_out (flag_out),
        .flag_we  (flag_we)
    );

    // Reference model built from the requirement text.
    task automatic model(input int op, input int a, input int b, input int f,
                         output int ea, output int ef, output int ew, output string tag);
        int d;
        ea = a; ef = f; ew = 0; tag = "R9";
        case (op)
            'hF4, 'hFC: begin d = a + b;     ea = d & M; ef = (d >> W) & 1; ew = 1; tag = "R1"; end
            'h74, 'h7C: begin d = a + b + f; ea = d & M; ef = (d >> W) & 1; ew = 1; tag = "R1"; end
            'hF5, 'hFD: begin d = b - a;     ea = d & M; ef = (d >= 0); ew = 1; tag = "R2"; end
            'hF7, 'hFF: begin d = a - b;     ea = d & M; ef = (d >= 0); ew = 1; tag = "R3"; end
            'h75, 'h7D: begin d = b - a - (1 - f); ea = d & M; ef = (d >= 0); ew = 1; tag = "R4"; end
            'h77, 'h7F: begin d = a - b - (1 - f); ea = d & M; ef = (d >= 0); ew = 1; tag = "R4"; end
            'hF1, 'hF9: begin ea = a | b; tag = "R5"; end
            'hF2, 'hFA: begin ea = a & b; tag = "R5"; end
            'hF3, 'hFB: begin ea = a ^ b; tag = "R5"; end
            'hF6: begin ea = a >> 1; ef = a & 1; ew = 1; tag = "R6"; end
            'h76: begin ea = (a >> 1) | (f << (W - 1)); ef = a & 1; ew = 1; tag = "R6"; end
            'hFE: begin ea = (a << 1) & M; ef = (a >> (W - 1)) & 1; ew = 1; tag = "R7"; end
            'h7E: begin ea = ((a << 1) & M) | f; ef = (a >> (W - 1)) & 1; ew = 1; tag = "R7"; end
            default: ;
        endcase
    endtask

    task automatic compare(input int ea, input int ef, input int ew, input string tag, input int op);
        n_checks++;
        if (acc_out !== ea[W-1:0] || flag_out !== ef[0] || flag_we !== ew[0]) begin
            n_fail++;
            $display("FAIL %s op=%02h: acc/flag/we got %0h/%0b/%0b expected %0h/%0b/%0b",
                     tag, op, acc_out, flag_out, flag_we, ea, ef, ew);
        end
        // R8: arithmetic and shift opcodes raise the flag write enable (folded into ew above).
    endtask

    initial begin : stim
        int pa, pf, pw, pop;
        string ptag;
        bit have_prev;
        have_prev = 1'b0;
        pa = 0; pf = 0; pw = 0; pop = 0; ptag = "";
        repeat (3) @(negedge clk);
        // R10: reset state
        compare(0, 0, 0, "R10", 0);
        op_code = 8'hF4; acc_in = 4'hF; opnd_in = 4'h1; flag_in = 1'b1;
        @(negedge clk);
        compare(0, 0, 0, "R10", 'hF4);   // still held in reset
        rst = 1'b0;
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 2; f++) begin
                for (int a = 0; a <= M; a++) begin
                    for (int b = 0; b <= M; b++) begin
                        op_code = op[7:0]; acc_in = a[W-1:0]; opnd_in = b[W-1:0]; flag_in = f[0];
                        @(negedge clk);
                        // R10: result appears one edge after the inputs
                        model(op, a, b, f, pa, pf, pw, ptag);
                        pop = op;
                        compare(pa, pf, pw, ptag, pop);
                        have_prev = 1'b1;
                    end
                end
            end
        end
        // R10: synchronous reset clears outputs again
        op_code = 8'hFE; acc_in = 4'h8; flag_in = 1'b1; rst = 1'b1;
        @(negedge clk);
        compare(0, 0, 0, "R10", 'hFE);
        if (!have_prev) n_fail++;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog expired: got running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule